// File: doc/BRIEF.md
# Continued-Fraction Ratio Approximation Engine

This engine turns a requested rate and an input rate, both 64-bit unsigned integers, into a multiplier/divisor pair N/D. Each term is limited to 16 bits, and input × N / D comes as close to the request as the continued-fraction expansion of request/input allows. A clock-tree controller would use it before programming a fractional divider. The controller raises `start` with the two rates and a set of mode flags. It waits for `done`, then either uses the result, which `commit_o` marks, or reads an error flag.

The expansion runs one partial quotient at a time on a shared multi-cycle restoring divider. It stops when the remainder runs out or when a term reaches the 16-bit ceiling. If the last term overshot, the engine falls back to the convergent before it. An optional one-step nudge on N or D then moves the achieved rate to the requested side of the target, and range checks follow. The achieved rate is recomputed as floor(input × N / D) with a shift-add multiplier and the same divider, at the full 80-bit width. A dry-run flag gives the same report without the commit strobe.

Top module: `cf_approx_engine`

## Requirements
- R1: `start` is taken only while `busy_o` is low. `busy_o` is high from the next cycle until the result is out. `done_o` is a one-cycle pulse in the cycle `busy_o` falls. A `start` or operand change during `busy_o` has no effect on the result.
- R2: The expansion begins with remainder fraction request/input and convergents 0/1 (older) and 1/0 (newer). Each step takes q = floor(a/b) of the remainder pair a/b and replaces the pair with b/(a mod b). It forms the new numerator as older + q·newer, and the new denominator the same way.
- R3: Steps continue while the remainder divisor is nonzero and both newest terms are below 65535. If the newest numerator or denominator then exceeds 65535, the older convergent is the result.
- R4: With round-up set and an achieved rate below the request, N is raised by one when N > D and D > 1. Otherwise D is lowered by one.
- R5: With round-down set and an achieved rate above the request, N is lowered by one when N > D and N > 1. Otherwise D is raised by one. The round-down branch is used only when the round-up branch does not apply. A zero D counts as a rate above any request.
- R6: If N or D exceeds 65535 after the nudge, `err_range_o` is set with `done_o`. `num_o`, `den_o` and `rate_o` then read zero and `commit_o` stays low.
- R7: If D is zero after the nudge, `err_inval_o` is set with `done_o`, the outputs read zero, and no commit occurs. A committed result never has `den_o` equal to zero.
- R8: `rate_o` on success is floor(input × N / D), computed at 80 bits with no truncation.
- R9: With neither rounding flag and no dry run, a recomputed rate that differs from the request gives `err_range_o` with zero outputs and no commit.
- R10: With dry run set, N, D and the rate are reported as on success and `commit_o` stays low. The exact-match check of R9 is skipped.
- R11: `commit_o` pulses together with `done_o` only for an error-free run without dry run.
- R12: At most one error flag is high. All result outputs hold their values from one `done_o` until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin a computation (used only while idle) |
| req_rate_i | input | 64 | Requested output rate |
| in_rate_i | input | 64 | Input rate |
| rnd_up_i | input | 1 | Nudge the result upward when below the request |
| rnd_dn_i | input | 1 | Nudge the result downward when above the request |
| dry_run_i | input | 1 | Report without commit strobe |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| commit_o | output | 1 | Result may be applied (pulses with done) |
| err_range_o | output | 1 | Term out of range or inexact result |
| err_inval_o | output | 1 | Divisor term is zero |
| num_o | output | 16 | Result N |
| den_o | output | 16 | Result D |
| rate_o | output | 80 | Achieved rate input × N / D |

## Verification
The assertions assume `start_i` is driven only after the internal reset release. They make no assumption about operands, since these are captured on acceptance, but they do rely on the output registers changing only in the cycle that raises `done_o`. The stimulus keeps `start_i` low for several cycles after reset. It drives every input half a cycle away from the rising edge. It deliberately raises `start_i` with changed operands in the middle of a run to show the capture holds. The operand set mixes exact ratios, zero request and zero input, ratios whose quotient saturates the first term, a crafted ratio whose nudged N reaches 65536, and pseudo-random pairs under every mode combination.

// File: rtl/cf_approx_pkg.sv
package cf_approx_pkg;

  // Sequencer states of the approximation engine.
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOOP,
    ST_QDIV,
    ST_PRE,
    ST_MUL,
    ST_RDIV,
    ST_ROUND,
    ST_RCHK,
    ST_FINAL
  } cf_state_e;

  // Mode flags captured when a request is accepted.
  typedef struct packed {
    logic rnd_up;
    logic rnd_dn;
    logic dry;
  } cf_mode_t;

endpackage

// File: rtl/cf_divider.sv
// Restoring divider, one quotient bit per cycle, W cycles per division.
module cf_divider #(
  parameter int W = 80
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [W-1:0] dividend_i,
  input  logic [W-1:0] divisor_i,
  output logic         done_o,
  output logic [W-1:0] quot_o,
  output logic [W-1:0] rem_o
);

  localparam int CW = $clog2(W + 1);

  logic          act_q, act_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  quo_q, quo_d;
  logic [W-1:0]  dvs_q, dvs_d;
  logic [W:0]    trial;
  logic [W:0]    diff;
  logic          en;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    done_d = 1'b0;
    trial  = {rem_q, quo_q[W-1]};
    diff   = trial - {1'b0, dvs_q};
    if (start_i) begin
      act_d = 1'b1;
      cnt_d = '0;
      rem_d = '0;
      quo_d = dividend_i;
      dvs_d = divisor_i;
    end else if (act_q) begin
      if (trial >= {1'b0, dvs_q}) begin
        rem_d = diff[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b1};
      end else begin
        rem_d = trial[W-1:0];
        quo_d = {quo_q[W-2:0], 1'b0};
      end
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(W - 1)) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  assign en = start_i | act_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
    end else begin
      done_q <= done_d;
      if (en) begin
        act_q <= act_d;
        cnt_q <= cnt_d;
        rem_q <= rem_d;
        quo_q <= quo_d;
        dvs_q <= dvs_d;
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quo_q;
  assign rem_o  = rem_q;

endmodule

// File: rtl/cf_rate_mul.sv
// Shift-add multiplier: one multiplier bit per cycle, BW cycles.
module cf_rate_mul #(
  parameter int AW = 64,
  parameter int BW = 16
) (
  input  logic            clk_i,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [AW-1:0]   a_i,
  input  logic [BW-1:0]   b_i,
  output logic            done_o,
  output logic [AW+BW-1:0] prod_o
);

  localparam int PW = AW + BW;
  localparam int CW = $clog2(BW + 1);

  logic          act_q, act_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] acc_q, acc_d;
  logic [PW-1:0] mc_q, mc_d;
  logic [BW-1:0] mp_q, mp_d;
  logic          en;

  always_comb begin
    act_d  = act_q;
    cnt_d  = cnt_q;
    acc_d  = acc_q;
    mc_d   = mc_q;
    mp_d   = mp_q;
    done_d = 1'b0;
    if (start_i) begin
      act_d = 1'b1;
      cnt_d = '0;
      acc_d = '0;
      mc_d  = {{BW{1'b0}}, a_i};
      mp_d  = b_i;
    end else if (act_q) begin
      if (mp_q[0]) acc_d = acc_q + mc_q;
      mc_d  = {mc_q[PW-2:0], 1'b0};
      mp_d  = {1'b0, mp_q[BW-1:1]};
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(BW - 1)) begin
        act_d  = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  assign en = start_i | act_q;

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      acc_q  <= '0;
      mc_q   <= '0;
      mp_q   <= '0;
    end else begin
      done_q <= done_d;
      if (en) begin
        act_q <= act_d;
        cnt_q <= cnt_d;
        acc_q <= acc_d;
        mc_q  <= mc_d;
        mp_q  <= mp_d;
      end
    end
  end

  assign done_o = done_q;
  assign prod_o = acc_q;

endmodule

// File: rtl/cf_term_step.sv
// One convergent term update: next = prev + q*cur, saturated at 2^TW.
// Any value above the term ceiling is discarded later, so saturation
// keeps every compare exact while the arithmetic stays TW+1 bits wide.
module cf_term_step #(
  parameter int QW = 80,
  parameter int TW = 16
) (
  input  logic [QW-1:0] q_i,
  input  logic [TW:0]   prev_i,
  input  logic [TW:0]   cur_i,
  output logic [TW:0]   next_o
);

  localparam int        TV  = TW + 1;
  localparam logic [TW:0] CAP = {1'b1, {TW{1'b0}}};

  logic [TW:0]     q_sat;
  logic [2*TV-1:0] prod;
  logic [2*TV:0]   sum;

  always_comb begin
    if (q_i > {{(QW-TV){1'b0}}, CAP}) q_sat = CAP;
    else                              q_sat = q_i[TW:0];
    prod = {{TV{1'b0}}, q_sat} * {{TV{1'b0}}, cur_i};
    sum  = {1'b0, prod} + {{(TV+1){1'b0}}, prev_i};
    if (sum > {{(TV+1){1'b0}}, CAP}) next_o = CAP;
    else                             next_o = sum[TW:0];
  end

endmodule

// File: rtl/cf_approx_engine.sv
module cf_approx_engine
  import cf_approx_pkg::*;
#(
  parameter int RATE_W = 64,
  parameter int TERM_W = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_n_i,
  input  logic                     start_i,
  input  logic [RATE_W-1:0]        req_rate_i,
  input  logic [RATE_W-1:0]        in_rate_i,
  input  logic                     rnd_up_i,
  input  logic                     rnd_dn_i,
  input  logic                     dry_run_i,
  output logic                     busy_o,
  output logic                     done_o,
  output logic                     commit_o,
  output logic                     err_range_o,
  output logic                     err_inval_o,
  output logic [TERM_W-1:0]        num_o,
  output logic [TERM_W-1:0]        den_o,
  output logic [RATE_W+TERM_W-1:0] rate_o
);

  localparam int           PW  = RATE_W + TERM_W;
  localparam int           TV  = TERM_W + 1;
  localparam logic [TV-1:0] LIM = {1'b0, {TERM_W{1'b1}}};
  localparam logic [TV-1:0] ONE = TV'(1);

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_n;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) rsync_q <= 2'b00;
    else          rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_n = rsync_q[1];

  // State
  cf_state_e     state_q, state_d;
  cf_mode_t      mode_q, mode_d;
  logic [RATE_W-1:0] req_q, req_d;
  logic [RATE_W-1:0] in_q, in_d;
  logic [PW-1:0] nrem_q, nrem_d, drem_q, drem_d;
  logic [TV-1:0] np_q, np_d, dp_q, dp_d, nc_q, nc_d, dc_q, dc_d;
  logic [TV-1:0] nres_q, nres_d, dres_q, dres_d;
  logic [PW-1:0] rate_q, rate_d;
  logic          inf_q, inf_d;
  logic          phase_q, phase_d;
  logic          done_q, done_d, commit_q, commit_d;
  logic          erng_q, erng_d, einv_q, einv_d;
  logic [TERM_W-1:0] num_q, num_d, den_q, den_d;
  logic [PW-1:0] orate_q, orate_d;

  // Shared arithmetic
  logic          div_start, div_done;
  logic [PW-1:0] div_a, div_b, div_quot, div_rem;
  logic          mul_start, mul_done;
  logic [PW-1:0] mul_prod;
  logic [PW-1:0] req_ext;
  logic          rate_lt, rate_gt;

  cf_divider #(.W(PW)) u_div (
    .clk_i      (clk_i),
    .rst_n      (rst_n),
    .start_i    (div_start),
    .dividend_i (div_a),
    .divisor_i  (div_b),
    .done_o     (div_done),
    .quot_o     (div_quot),
    .rem_o      (div_rem)
  );

  cf_rate_mul #(.AW(RATE_W), .BW(TERM_W)) u_mul (
    .clk_i   (clk_i),
    .rst_n   (rst_n),
    .start_i (mul_start),
    .a_i     (in_q),
    .b_i     (nres_q[TERM_W-1:0]),
    .done_o  (mul_done),
    .prod_o  (mul_prod)
  );

  // Numerator (index 0) and denominator (index 1) term updates.
  logic [TV-1:0] step_prev [2];
  logic [TV-1:0] step_cur  [2];
  logic [TV-1:0] step_next [2];

  assign step_prev[0] = np_q;
  assign step_prev[1] = dp_q;
  assign step_cur[0]  = nc_q;
  assign step_cur[1]  = dc_q;

  for (genvar g = 0; g < 2; g++) begin : g_term
    cf_term_step #(.QW(PW), .TW(TERM_W)) u_step (
      .q_i    (div_quot),
      .prev_i (step_prev[g]),
      .cur_i  (step_cur[g]),
      .next_o (step_next[g])
    );
  end

  assign req_ext = {{TERM_W{1'b0}}, req_q};
  assign rate_lt = !inf_q && (rate_q < req_ext);
  assign rate_gt = inf_q || (rate_q > req_ext);

  always_comb begin
    state_d   = state_q;
    mode_d    = mode_q;
    req_d     = req_q;
    in_d      = in_q;
    nrem_d    = nrem_q;
    drem_d    = drem_q;
    np_d      = np_q;
    dp_d      = dp_q;
    nc_d      = nc_q;
    dc_d      = dc_q;
    nres_d    = nres_q;
    dres_d    = dres_q;
    rate_d    = rate_q;
    inf_d     = inf_q;
    phase_d   = phase_q;
    done_d    = 1'b0;
    commit_d  = 1'b0;
    erng_d    = erng_q;
    einv_d    = einv_q;
    num_d     = num_q;
    den_d     = den_q;
    orate_d   = orate_q;
    div_start = 1'b0;
    div_a     = '0;
    div_b     = '0;
    mul_start = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          mode_d  = '{rnd_up: rnd_up_i, rnd_dn: rnd_dn_i, dry: dry_run_i};
          req_d   = req_rate_i;
          in_d    = in_rate_i;
          nrem_d  = {{TERM_W{1'b0}}, req_rate_i};
          drem_d  = {{TERM_W{1'b0}}, in_rate_i};
          np_d    = '0;
          dp_d    = ONE;
          nc_d    = ONE;
          dc_d    = '0;
          phase_d = 1'b0;
          inf_d   = 1'b0;
          state_d = ST_LOOP;
        end
      end

      ST_LOOP: begin
        if ((drem_q != '0) && (nc_q < LIM) && (dc_q < LIM)) begin
          div_start = 1'b1;
          div_a     = nrem_q;
          div_b     = drem_q;
          state_d   = ST_QDIV;
        end else begin
          if ((nc_q > LIM) || (dc_q > LIM)) begin
            nres_d = np_q;
            dres_d = dp_q;
          end else begin
            nres_d = nc_q;
            dres_d = dc_q;
          end
          state_d = ST_PRE;
        end
      end

      ST_QDIV: begin
        if (div_done) begin
          nrem_d  = drem_q;
          drem_d  = div_rem;
          np_d    = nc_q;
          nc_d    = step_next[0];
          dp_d    = dc_q;
          dc_d    = step_next[1];
          state_d = ST_LOOP;
        end
      end

      ST_PRE: begin
        if (dres_q == '0) begin
          inf_d   = 1'b1;
          state_d = ST_ROUND;
        end else begin
          mul_start = 1'b1;
          state_d   = ST_MUL;
        end
      end

      ST_MUL: begin
        if (mul_done) begin
          div_start = 1'b1;
          div_a     = mul_prod;
          div_b     = {{(PW-TV){1'b0}}, dres_q};
          state_d   = ST_RDIV;
        end
      end

      ST_RDIV: begin
        if (div_done) begin
          rate_d  = div_quot;
          state_d = phase_q ? ST_FINAL : ST_ROUND;
        end
      end

      ST_ROUND: begin
        if (mode_q.rnd_up && rate_lt) begin
          if ((nres_q > dres_q) && (dres_q > ONE)) nres_d = nres_q + ONE;
          else                                     dres_d = dres_q - ONE;
        end else if (mode_q.rnd_dn && rate_gt) begin
          if ((nres_q > dres_q) && (nres_q > ONE)) nres_d = nres_q - ONE;
          else                                     dres_d = dres_q + ONE;
        end
        state_d = ST_RCHK;
      end

      ST_RCHK: begin
        if ((nres_q > LIM) || (dres_q > LIM) || (dres_q == '0)) begin
          done_d  = 1'b1;
          erng_d  = (nres_q > LIM) || (dres_q > LIM);
          einv_d  = !((nres_q > LIM) || (dres_q > LIM));
          num_d   = '0;
          den_d   = '0;
          orate_d = '0;
          state_d = ST_IDLE;
        end else begin
          phase_d = 1'b1;
          inf_d   = 1'b0;
          state_d = ST_PRE;
        end
      end

      ST_FINAL: begin
        done_d  = 1'b1;
        einv_d  = 1'b0;
        state_d = ST_IDLE;
        if (!mode_q.dry && !mode_q.rnd_up && !mode_q.rnd_dn && (rate_q != req_ext)) begin
          erng_d  = 1'b1;
          num_d   = '0;
          den_d   = '0;
          orate_d = '0;
        end else begin
          erng_d   = 1'b0;
          commit_d = !mode_q.dry;
          num_d    = nres_q[TERM_W-1:0];
          den_d    = dres_q[TERM_W-1:0];
          orate_d  = rate_q;
        end
      end

      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mode_q   <= '0;
      req_q    <= '0;
      in_q     <= '0;
      nrem_q   <= '0;
      drem_q   <= '0;
      np_q     <= '0;
      dp_q     <= '0;
      nc_q     <= '0;
      dc_q     <= '0;
      nres_q   <= '0;
      dres_q   <= '0;
      rate_q   <= '0;
      inf_q    <= 1'b0;
      phase_q  <= 1'b0;
      done_q   <= 1'b0;
      commit_q <= 1'b0;
      erng_q   <= 1'b0;
      einv_q   <= 1'b0;
      num_q    <= '0;
      den_q    <= '0;
      orate_q  <= '0;
    end else begin
      state_q  <= state_d;
      done_q   <= done_d;
      commit_q <= commit_d;
      if (state_q != ST_IDLE || start_i) begin
        mode_q  <= mode_d;
        req_q   <= req_d;
        in_q    <= in_d;
        nrem_q  <= nrem_d;
        drem_q  <= drem_d;
        np_q    <= np_d;
        dp_q    <= dp_d;
        nc_q    <= nc_d;
        dc_q    <= dc_d;
        nres_q  <= nres_d;
        dres_q  <= dres_d;
        rate_q  <= rate_d;
        inf_q   <= inf_d;
        phase_q <= phase_d;
      end
      if (done_d) begin
        erng_q  <= erng_d;
        einv_q  <= einv_d;
        num_q   <= num_d;
        den_q   <= den_d;
        orate_q <= orate_d;
      end
    end
  end

  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = done_q;
  assign commit_o    = commit_q;
  assign err_range_o = erng_q;
  assign err_inval_o = einv_q;
  assign num_o       = num_q;
  assign den_o       = den_q;
  assign rate_o      = orate_q;

endmodule

// File: rtl/cf_approx_checker.sv
module cf_approx_checker #(
  parameter int RATE_W = 64,
  parameter int TERM_W = 16
) (
  input logic                     clk_i,
  input logic                     rst_n,
  input logic                     start_i,
  input logic                     busy_o,
  input logic                     done_o,
  input logic                     commit_o,
  input logic                     err_range_o,
  input logic                     err_inval_o,
  input logic [TERM_W-1:0]        num_o,
  input logic [TERM_W-1:0]        den_o,
  input logic [RATE_W+TERM_W-1:0] rate_o
);

  assert_done_pulse_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_not_busy_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    done_o |-> !busy_o);

  assert_start_taken_R1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  assert_error_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_n)
    (done_o && err_range_o) |-> (num_o == '0 && den_o == '0 && rate_o == '0));

  assert_commit_den_R7: assert property (@(posedge clk_i) disable iff (!rst_n)
    commit_o |-> (den_o != '0));

  assert_commit_clean_R11: assert property (@(posedge clk_i) disable iff (!rst_n)
    commit_o |-> (done_o && !err_range_o && !err_inval_o));

  assert_one_error_R12: assert property (@(posedge clk_i) disable iff (!rst_n)
    $onehot0({err_range_o, err_inval_o}));

  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!busy_o && !start_i) |=> ($stable(num_o) && $stable(den_o) && $stable(rate_o)
                               && $stable(err_range_o) && $stable(err_inval_o)));

endmodule

bind cf_approx_engine cf_approx_checker #(.RATE_W(RATE_W), .TERM_W(TERM_W)) u_cf_chk (
  .clk_i       (clk_i),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .commit_o    (commit_o),
  .err_range_o (err_range_o),
  .err_inval_o (err_inval_o),
  .num_o       (num_o),
  .den_o       (den_o),
  .rate_o      (rate_o)
);

// File: tb/test_cf_approx_engine.sv
`timescale 1ns/1ps
module test_cf_approx_engine;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [63:0] req_rate, in_rate;
  logic        up, dn, dry;
  logic        busy, done, commit, erng, einv;
  logic [15:0] num, den;
  logic [79:0] rate;

  int checks;
  int errors;
  bit finished;

  cf_approx_engine i_cf_approx_engine (
    .clk_i       (clk),
    .rst_n_i     (rst_n),
    .start_i     (start),
    .req_rate_i  (req_rate),
    .in_rate_i   (in_rate),
    .rnd_up_i    (up),
    .rnd_dn_i    (dn),
    .dry_run_i   (dry),
    .busy_o      (busy),
    .done_o      (done),
    .commit_o    (commit),
    .err_range_o (erng),
    .err_inval_o (einv),
    .num_o       (num),
    .den_o       (den),
    .rate_o      (rate)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  // Behavioural model of the requirements, on wide integers.
  function automatic void ref_op(input logic [63:0] rq, ir, input bit u, d, y,
                                 output logic [15:0] n_o, d_o, output logic [79:0] r_o,
                                 output bit er, ei, cm);
    logic [127:0] nr, dr, np, dp, nc, dc, q, t, n, dd, r;
    bit inf;
    nr = 128'(rq); dr = 128'(ir);
    np = 0; dp = 1; nc = 1; dc = 0;
    while (dr != 0 && nc < 65535 && dc < 65535) begin
      q = nr / dr;
      t = dr; dr = nr % dr; nr = t;
      t = np + q * nc; np = nc; nc = t;
      t = dp + q * dc; dp = dc; dc = t;
    end
    if (nc > 65535 || dc > 65535) begin n = np; dd = dp; end
    else begin n = nc; dd = dc; end
    inf = (dd == 0);
    r = inf ? 128'd0 : (128'(ir) * n) / dd;
    if (u && !inf && r < 128'(rq)) begin
      if (n > dd && dd > 1) n = n + 1; else dd = dd - 1;
    end else if (d && (inf || r > 128'(rq))) begin
      if (n > dd && n > 1) n = n - 1; else dd = dd + 1;
    end
    er = 0; ei = 0; cm = 0; n_o = 0; d_o = 0; r_o = 0;
    if (n > 65535 || dd > 65535) er = 1;
    else if (dd == 0) ei = 1;
    else begin
      r = (128'(ir) * n) / dd;
      if (!y && !u && !d && r != 128'(rq)) er = 1;
      else begin
        n_o = n[15:0]; d_o = dd[15:0]; r_o = r[79:0]; cm = !y;
      end
    end
  endfunction

  task automatic run_op(input logic [63:0] rq, ir, input bit u, d, y,
                        input bit poke, input string tag);
    logic [15:0] en, ed;
    logic [79:0] er_rate;
    bit eer, eei, ecm, got;
    int cyc;
    ref_op(rq, ir, u, d, y, en, ed, er_rate, eer, eei, ecm);
    @(negedge clk);
    req_rate = rq; in_rate = ir; up = u; dn = d; dry = y; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    got = 0; cyc = 0;
    while (!got && cyc < 20000) begin
      if (done) begin
        got = 1;
        chk(num == en && den == ed && rate == er_rate && erng == eer && einv == eei
            && commit == ecm, tag,
            $sformatf("req=%0d in=%0d m=%0b%0b%0b got N=%0d D=%0d rate=%0d er=%0b ei=%0b c=%0b exp N=%0d D=%0d rate=%0d er=%0b ei=%0b c=%0b",
                      rq, ir, u, d, y, num, den, rate, erng, einv, commit,
                      en, ed, er_rate, eer, eei, ecm));
      end else begin
        // R1: busy through the whole run; a mid-run start with other operands is ignored
        chk(busy == 1'b1, "R1", $sformatf("busy=%0b exp 1 at cycle %0d", busy, cyc));
        if (poke && cyc == 3) begin
          start = 1'b1; req_rate = ~rq; in_rate = rq; up = ~u; dry = ~y;
        end else start = 1'b0;
        @(negedge clk);
        cyc++;
      end
    end
    start = 1'b0;
    if (!got) chk(1'b0, "R1", $sformatf("no done after %0d cycles, exp done", cyc));
    else begin
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0 && commit == 1'b0, "R1",
          $sformatf("after done: done=%0b busy=%0b commit=%0b exp 0 0 0", done, busy, commit));
      repeat (3) @(negedge clk);
      chk(num == en && den == ed && rate == er_rate && erng == eer && einv == eei, "R12",
          $sformatf("held N=%0d D=%0d rate=%0d exp N=%0d D=%0d rate=%0d", num, den, rate, en, ed, er_rate));
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not end, got timeout exp completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] s;
    checks = 0; errors = 0; finished = 0;
    rst_n = 1'b0; start = 1'b0; req_rate = '0; in_rate = '0;
    up = 1'b0; dn = 1'b0; dry = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && commit == 0 && erng == 0 && einv == 0 && num == 0 && den == 0,
        "R1", $sformatf("reset: busy=%0b done=%0b N=%0d D=%0d exp all 0", busy, done, num, den));
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    chk(busy == 0 && done == 0 && rate == 0, "R12",
        $sformatf("post-reset idle busy=%0b rate=%0d exp 0", busy, rate));

    run_op(64'd50, 64'd100, 0, 0, 0, 0, "R2");            // exact 1/2
    run_op(64'd0, 64'd9, 0, 0, 0, 0, "R8");               // zero request -> 0/1
    run_op(64'd3, 64'd7, 0, 0, 0, 1, "R1");               // mid-run start ignored
    run_op(64'd33333333, 64'd100000000, 0, 0, 0, 0, "R9");
    run_op(64'd33333333, 64'd100000000, 1, 0, 0, 0, "R4");
    run_op(64'd33333333, 64'd100000000, 0, 1, 0, 0, "R5");
    run_op(64'd33333333, 64'd100000000, 1, 1, 0, 0, "R5");
    run_op(64'd314159265, 64'd100000000, 0, 0, 1, 0, "R10");
    run_op(64'd314159265, 64'd100000000, 0, 1, 0, 0, "R11");
    run_op(64'd65567768, 64'd2001, 1, 0, 0, 0, "R6");     // N nudged to 65536
    run_op(64'd65567768, 64'd2001, 0, 0, 0, 0, "R3");     // stops at 65535/2, inexact
    run_op(64'd65567768, 64'd2001, 0, 0, 1, 0, "R3");
    run_op(64'd1048575, 64'd1, 0, 0, 0, 0, "R3");         // saturated term -> 1/0 fallback
    run_op(64'd1048575, 64'd1, 0, 1, 0, 0, "R5");         // zero D counts as too high
    run_op(64'd5, 64'd0, 0, 0, 0, 0, "R7");               // zero input -> D zero
    run_op(64'd5, 64'd0, 1, 0, 0, 0, "R7");
    run_op(64'd5, 64'd0, 0, 1, 0, 0, "R8");
    run_op(64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE, 0, 0, 1, 0, "R8");

    s = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 14; i++) begin
      logic [63:0] a, b;
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      a = s >> (i * 3);
      s = s ^ (s << 13); s = s ^ (s >> 7); s = s ^ (s << 17);
      b = s >> ((13 - i) * 3);
      run_op(a, b, i[0], i[1], i[2], 0, "R2");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule